// File: doc/BRIEF.md
# Address-Translation Register Write Legalizer

This block holds the three address-translation control registers of a hart that supports a hypervisor: the supervisor register, the virtual-supervisor register and the guest-stage register. Each one is 64 bits wide and has a 4-bit MODE field, a tag field and a physical page number (PPN) field. A single CSR port writes them. Read data for the currently addressed register is returned combinationally. Every write is legalized before it is stored. MODE is checked against the supported translation schemes. The PPN is cut to the width the hardware can actually hold, and that width depends on the register and, for the virtual-supervisor register, on the guest-stage MODE that is set at the time of the write.

The two first-stage registers drop a write whose MODE is not supported, so the register keeps its old value. The guest-stage register never drops a write: it forces an unsupported MODE to Bare and stores its other fields anyway. The tag of the first-stage registers is an address-space identifier. When a stored identifier changes, a one-cycle pulse is raised so that translation caches can react. The pulse is registered, so it is high in the same cycle in which the new register value first appears on the read port. The guest-stage tag is a virtual-machine identifier and has its own pulse.

Top module: `atp_csr_file`

## Requirements
- R1: The supervisor register is at address 0x180, the virtual-supervisor register at 0x280 and the guest-stage register at 0x680. Each has MODE in bits 63:60, its tag starting at bit 44 and the PPN in bits 43:0. `csr_rdata` shows the addressed register combinationally. Any other address reads zero and a write to it changes nothing.
- R2: After reset all three registers read zero and both change pulses are low.
- R3: The supervisor PPN keeps its lowest PA_BITS-12 bits (24 by default). The higher PPN bits always read zero.
- R4: The virtual-supervisor PPN keeps PA_BITS-12 bits when the guest-stage MODE is Bare (0). It keeps 41-12 = 29 bits when the guest-stage MODE is Sv39x4 (8). The width is chosen from the guest-stage MODE at the time of the write.
- R5: The guest-stage PPN keeps its lowest PA_BITS-12 bits, and PPN bits 1:0 always read zero. Its tag is 14 bits (57:44), and bits 59:58 always read zero.
- R6: A supervisor or virtual-supervisor write whose MODE is neither Bare (0) nor Sv39 (8) is ignored entirely: MODE, tag and PPN keep their old values and no pulse is raised.
- R7: A guest-stage write whose MODE is neither 0 nor 8 stores MODE as 0 (Bare). Its tag and PPN are still written under R5.
- R8: `asid_chg` is high for exactly one cycle, the cycle after an accepted supervisor or virtual-supervisor write whose 16-bit tag (59:44) differs from the stored tag. That is the first cycle in which the new value is readable. A write with an unchanged tag gives no pulse.
- R9: `vmid_chg` follows the same rule for guest-stage writes whose 14-bit tag (57:44) differs from the stored one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_we | input | 1 | Write enable for the CSR port |
| csr_addr | input | 12 | CSR address for both read and write |
| csr_wdata | input | 64 | Write data |
| csr_rdata | output | 64 | Legalized content of the addressed register |
| asid_chg | output | 1 | One-cycle pulse when a first-stage tag has changed |
| vmid_chg | output | 1 | One-cycle pulse when the guest-stage tag has changed |

## Verification
The supervisor and virtual-supervisor registers are written with all-ones PPN patterns. These show whether the kept width is 24 or 29 bits, and the virtual-supervisor pattern is written once under each guest-stage MODE so that a mask taken from the wrong source is caught. The guest-stage register is written with all ones, which shows that the two low PPN bits and the two high tag bits are cleared. It is also written with an odd MODE value, which shows that MODE is forced to Bare while the tag and PPN are still stored. Several writes repeat an unchanged tag, so a pulse raised on every write is told apart from a pulse raised only on a change. Unsupported MODE values on the first-stage registers, and a write to an unmapped address, show that a dropped write leaves the register and both pulses untouched.

// File: rtl/atp_pkg.sv
package atp_pkg;
  localparam int unsigned XLEN      = 64;
  localparam int unsigned MODE_LSB  = 60;
  localparam int unsigned MODE_W    = 4;
  localparam int unsigned TAG_LSB   = 44;
  localparam int unsigned TAG_W     = 16;
  localparam int unsigned GTAG_W    = 14;
  localparam int unsigned PPN_W     = 44;
  localparam int unsigned SV39X4_PA = 41;

  localparam logic [MODE_W-1:0] MODE_BARE = 4'h0;
  localparam logic [MODE_W-1:0] MODE_SV39 = 4'h8;

  typedef enum logic [1:0] {
    KIND_S  = 2'd0,
    KIND_VS = 2'd1,
    KIND_G  = 2'd2
  } atp_kind_e;

  // Ones in the lowest w bits of a PPN field.
  function automatic logic [PPN_W-1:0] ppn_mask(input int unsigned w);
    logic [PPN_W-1:0] m;
    for (int i = 0; i < PPN_W; i++) m[i] = (i < w);
    return m;
  endfunction

  // Writable PPN width of the virtual-supervisor register.
  function automatic int unsigned vs_ppn_width(input int unsigned pa_bits,
                                               input int unsigned pg_ofs,
                                               input logic g_sv39x4);
    return g_sv39x4 ? (SV39X4_PA - pg_ofs) : (pa_bits - pg_ofs);
  endfunction

  function automatic logic mode_supported(input logic [MODE_W-1:0] m);
    return (m == MODE_BARE) || (m == MODE_SV39);
  endfunction
endpackage

// File: rtl/atp_legalize.sv
module atp_legalize
  import atp_pkg::*;
#(
  parameter atp_kind_e   KIND    = KIND_S,
  parameter int unsigned PA_BITS = 36,
  parameter int unsigned PG_OFS  = 12
) (
  input  logic [XLEN-1:0] wdata,
  input  logic            g_sv39x4,
  output logic            accept,
  output logic [XLEN-1:0] nxt
);
  localparam int unsigned BASE_W = PA_BITS - PG_OFS;
  localparam logic [TAG_W-1:0] TAG_KEEP =
    (KIND == KIND_G) ? TAG_W'((1 << GTAG_W) - 1) : '1;

  logic [MODE_W-1:0] mode_in;
  logic              mode_ok;
  logic [TAG_W-1:0]  tag_in;
  logic [PPN_W-1:0]  ppn_in;
  int unsigned       ppn_w;

  always_comb begin
    mode_in = wdata[MODE_LSB +: MODE_W];
    mode_ok = mode_supported(mode_in);
    tag_in  = wdata[TAG_LSB +: TAG_W] & TAG_KEEP;
    ppn_w   = (KIND == KIND_VS) ? vs_ppn_width(PA_BITS, PG_OFS, g_sv39x4) : BASE_W;
    ppn_in  = wdata[PPN_W-1:0] & ppn_mask(ppn_w);
  end

  generate
    if (KIND == KIND_G) begin : g_guest
      // Fields are legalized one by one; the write always lands.
      assign accept = 1'b1;
      assign nxt    = {mode_ok ? mode_in : MODE_BARE, tag_in,
                       ppn_in & ~PPN_W'(3)};
    end else begin : g_first
      // Unsupported scheme: the whole write is dropped.
      assign accept = mode_ok;
      assign nxt    = {mode_in, tag_in, ppn_in};
    end
  endgenerate
endmodule

// File: rtl/atp_store.sv
module atp_store
  import atp_pkg::*;
#(
  parameter int unsigned T_LSB = TAG_LSB,
  parameter int unsigned T_W   = TAG_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [XLEN-1:0] nxt,
  output logic [XLEN-1:0] q,
  output logic            tag_chg
);
  logic tag_diff;
  assign tag_diff = nxt[T_LSB +: T_W] != q[T_LSB +: T_W];

  // The pulse is registered at the same edge as the value, so both appear together.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q       <= '0;
      tag_chg <= 1'b0;
    end else begin
      tag_chg <= we && tag_diff;
      if (we) q <= nxt;
    end
  end
endmodule

// File: rtl/atp_csr_file.sv
module atp_csr_file
  import atp_pkg::*;
#(
  parameter int unsigned PA_BITS   = 36,
  parameter int unsigned PG_OFS    = 12,
  parameter logic [11:0] ADDR_S    = 12'h180,
  parameter logic [11:0] ADDR_VS   = 12'h280,
  parameter logic [11:0] ADDR_G    = 12'h680
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            csr_we,
  input  logic [11:0]     csr_addr,
  input  logic [XLEN-1:0] csr_wdata,
  output logic [XLEN-1:0] csr_rdata,
  output logic            asid_chg,
  output logic            vmid_chg
);
  localparam int unsigned BASE_W = PA_BITS - PG_OFS;

  logic [XLEN-1:0] s_q, vs_q, g_q;
  logic [XLEN-1:0] s_nxt, vs_nxt, g_nxt;
  logic            s_ok, vs_ok, g_ok;
  logic            s_chg, vs_chg, g_chg;
  logic            g_sv39x4;

  // Named write events, used by the stores and by the assertions.
  logic s_hit, vs_hit, g_hit;
  logic s_wr, vs_wr, g_wr;
  logic s_wr_bad, vs_wr_bad;

  assign g_sv39x4  = g_q[MODE_LSB +: MODE_W] == MODE_SV39;
  assign s_hit     = csr_we && (csr_addr == ADDR_S);
  assign vs_hit    = csr_we && (csr_addr == ADDR_VS);
  assign g_hit     = csr_we && (csr_addr == ADDR_G);
  assign s_wr      = s_hit && s_ok;
  assign vs_wr     = vs_hit && vs_ok;
  assign g_wr      = g_hit && g_ok;
  assign s_wr_bad  = s_hit && !s_ok;
  assign vs_wr_bad = vs_hit && !vs_ok;

  atp_legalize #(.KIND(KIND_S),  .PA_BITS(PA_BITS), .PG_OFS(PG_OFS)) u_leg_s (
    .wdata(csr_wdata), .g_sv39x4(g_sv39x4), .accept(s_ok),  .nxt(s_nxt));
  atp_legalize #(.KIND(KIND_VS), .PA_BITS(PA_BITS), .PG_OFS(PG_OFS)) u_leg_vs (
    .wdata(csr_wdata), .g_sv39x4(g_sv39x4), .accept(vs_ok), .nxt(vs_nxt));
  atp_legalize #(.KIND(KIND_G),  .PA_BITS(PA_BITS), .PG_OFS(PG_OFS)) u_leg_g (
    .wdata(csr_wdata), .g_sv39x4(g_sv39x4), .accept(g_ok),  .nxt(g_nxt));

  atp_store #(.T_LSB(TAG_LSB), .T_W(TAG_W)) u_st_s (
    .clk(clk), .rst_n(rst_n), .we(s_wr),  .nxt(s_nxt),  .q(s_q),  .tag_chg(s_chg));
  atp_store #(.T_LSB(TAG_LSB), .T_W(TAG_W)) u_st_vs (
    .clk(clk), .rst_n(rst_n), .we(vs_wr), .nxt(vs_nxt), .q(vs_q), .tag_chg(vs_chg));
  atp_store #(.T_LSB(TAG_LSB), .T_W(GTAG_W)) u_st_g (
    .clk(clk), .rst_n(rst_n), .we(g_wr),  .nxt(g_nxt),  .q(g_q),  .tag_chg(g_chg));

  always_comb begin
    unique case (csr_addr)
      ADDR_S:  csr_rdata = s_q;
      ADDR_VS: csr_rdata = vs_q;
      ADDR_G:  csr_rdata = g_q;
      default: csr_rdata = '0;
    endcase
  end

  assign asid_chg = s_chg || vs_chg;
  assign vmid_chg = g_chg;

  // R3: supervisor PPN never holds bits above the writable width
  a_r3_s_ppn_width: assert property (@(posedge clk) disable iff (!rst_n)
    (s_q[PPN_W-1:0] & ~ppn_mask(BASE_W)) == '0);

  // R5: guest-stage low PPN bits and top tag bits stay clear
  a_r5_g_zero_bits: assert property (@(posedge clk) disable iff (!rst_n)
    g_q[1:0] == 2'b00 && g_q[TAG_LSB+GTAG_W +: 2] == 2'b00);

  // R6: dropped first-stage writes leave the register unchanged
  a_r6_s_bad_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    s_wr_bad |=> $stable(s_q));
  a_r6_vs_bad_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    vs_wr_bad |=> $stable(vs_q));

  // R7: a guest-stage write always lands with a supported MODE
  a_r7_g_mode_legal: assert property (@(posedge clk) disable iff (!rst_n)
    g_hit |=> mode_supported(g_q[MODE_LSB +: MODE_W]));

  // R8: the ASID pulse coincides with a visible tag change
  a_r8_asid_visible: assert property (@(posedge clk) disable iff (!rst_n)
    asid_chg |-> (s_q[TAG_LSB +: TAG_W] != $past(s_q[TAG_LSB +: TAG_W])) ||
                 (vs_q[TAG_LSB +: TAG_W] != $past(vs_q[TAG_LSB +: TAG_W])));

  // R9: the VMID pulse coincides with a visible tag change
  a_r9_vmid_visible: assert property (@(posedge clk) disable iff (!rst_n)
    vmid_chg |-> g_q[TAG_LSB +: GTAG_W] != $past(g_q[TAG_LSB +: GTAG_W]));
endmodule

// File: tb/atp_csr_file_test.sv
`timescale 1ns/1ps
module atp_csr_file_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        csr_we = 1'b0;
  logic [11:0] csr_addr = '0;
  logic [63:0] csr_wdata = '0;
  logic [63:0] csr_rdata;
  logic        asid_chg, vmid_chg;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  atp_csr_file uut (
    .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_addr(csr_addr),
    .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
    .asid_chg(asid_chg), .vmid_chg(vmid_chg));

  typedef struct packed {
    logic [11:0] addr;
    logic [63:0] wdata;
    logic [63:0] exp;
    logic        ea;
    logic        ev;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VEC [NV] = '{
    '{12'h180, 64'h8000_1FFF_FFFF_FFFF, 64'h8000_1000_00FF_FFFF, 1'b1, 1'b0},
    '{12'h180, 64'h8000_1000_0000_0123, 64'h8000_1000_0000_0123, 1'b0, 1'b0},
    '{12'h180, 64'h9000_2000_0000_0000, 64'h8000_1000_0000_0123, 1'b0, 1'b0},
    '{12'h180, 64'h0000_5000_0000_0001, 64'h0000_5000_0000_0001, 1'b1, 1'b0},
    '{12'h280, 64'h8003_0FFF_FFFF_FFFF, 64'h8003_0000_00FF_FFFF, 1'b1, 1'b0},
    '{12'h680, 64'h8FFF_FFFF_FFFF_FFFF, 64'h83FF_F000_00FF_FFFC, 1'b0, 1'b1},
    '{12'h280, 64'h8003_0FFF_FFFF_FFFF, 64'h8003_0000_1FFF_FFFF, 1'b0, 1'b0},
    '{12'h680, 64'h5001_2000_0000_0013, 64'h0001_2000_0000_0010, 1'b0, 1'b1},
    '{12'h280, 64'h8003_0FFF_FFFF_FFFF, 64'h8003_0000_00FF_FFFF, 1'b0, 1'b0},
    '{12'h280, 64'hA000_7000_0000_0000, 64'h8003_0000_00FF_FFFF, 1'b0, 1'b0},
    '{12'h123, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0000, 1'b0, 1'b0},
    '{12'h680, 64'h8001_2000_0000_0000, 64'h8001_2000_0000_0000, 1'b0, 1'b0},
    '{12'h280, 64'h8004_0000_0000_0000, 64'h8004_0000_0000_0000, 1'b1, 1'b0}
  };

  function automatic string vec_req(input int i);
    case (i)
      0:  return "R3";
      1:  return "R8";
      2:  return "R6";
      3:  return "R8";
      4:  return "R4";
      5:  return "R5";
      6:  return "R4";
      7:  return "R7";
      8:  return "R4";
      9:  return "R6";
      10: return "R1";
      11: return "R9";
      default: return "R8";
    endcase
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Issue one write; returns at the next falling edge, after the update.
  task automatic write_csr(input logic [11:0] a, input logic [63:0] d);
    @(negedge clk);
    csr_we = 1'b1; csr_addr = a; csr_wdata = d;
    @(negedge clk);
    csr_we = 1'b0;
  endtask

  task automatic read_csr(input logic [11:0] a, output logic [63:0] d);
    csr_addr = a;
    #0.5;
    d = csr_rdata;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 100000);
    fails++;
    $display("FAIL watchdog: run hung actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [63:0] rd;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R2: reset state
    read_csr(12'h180, rd); chk("R2", rd, 64'h0);
    read_csr(12'h280, rd); chk("R2", rd, 64'h0);
    read_csr(12'h680, rd); chk("R2", rd, 64'h0);
    chk("R2", {62'h0, asid_chg, vmid_chg}, 64'h0);

    for (int i = 0; i < NV; i++) begin
      write_csr(VEC[i].addr, VEC[i].wdata);
      // Pulse and new value are both visible now
      chk(vec_req(i), {62'h0, asid_chg, vmid_chg}, {62'h0, VEC[i].ea, VEC[i].ev});
      chk(vec_req(i), csr_rdata, VEC[i].exp);
      @(negedge clk);
      // R8 / R9: pulses last one cycle only
      chk("R8", {63'h0, asid_chg}, 64'h0);
      chk("R9", {63'h0, vmid_chg}, 64'h0);
    end

    // R1: readback by address after the sequence
    read_csr(12'h180, rd); chk("R1", rd, 64'h0000_5000_0000_0001);
    read_csr(12'h680, rd); chk("R1", rd, 64'h8001_2000_0000_0000);
    read_csr(12'h7FF, rd); chk("R1", rd, 64'h0);

    // R6: bad MODE with a different tag raises no pulse and keeps the old value
    write_csr(12'h180, 64'hF00F_F000_0000_0000);
    chk("R6", {63'h0, asid_chg}, 64'h0);
    chk("R6", csr_rdata, 64'h0000_5000_0000_0001);

    // R7: a guest-stage write with Sv39 MODE but an odd PPN still drops the low bits
    write_csr(12'h680, 64'h8001_2000_0000_0003);
    chk("R7", csr_rdata, 64'h8001_2000_0000_0000);
    chk("R9", {63'h0, vmid_chg}, 64'h0);

    // R2: mid-run reset clears everything
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    read_csr(12'h180, rd); chk("R2", rd, 64'h0);
    read_csr(12'h280, rd); chk("R2", rd, 64'h0);
    read_csr(12'h680, rd); chk("R2", rd, 64'h0);

    finish_run();
  end
endmodule